// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an external asynchronous static RAM that has a 15-bit address and an 8-bit data bus. The host hands over one word at a time through a valid/ready handshake: an address, a write flag and write data. The block then produces the active-low chip-select, output-enable and write-enable strobes for the RAM. It holds the address on the memory pins and controls the enable of the data-bus drivers. For a read it returns the captured byte with a one-cycle valid strobe.

Every phase length comes from the RAM's timing limits for the selected speed grade, divided by the clock period and rounded up to whole cycles, with one cycle as the minimum. A read holds the strobes for the longest of the cycle time, the address access time and the output-enable access time. A write holds write enable low for the longest of the pulse width, the address-to-end time and the data set-up time. After every read the block waits out the RAM's output release time before it accepts new work. Its own drivers therefore never turn on while the RAM may still be driving the bus.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, mem_cs_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, req_ready is 1 and rsp_valid is 0.
- R2: Each phase lasts max(1, ceil(t / CLK_PERIOD_NS)) cycles. SPEED_GRADE 0 uses t = 55/55/25 ns for read cycle, address access and enable access, 40/45/25 ns for write pulse, address-to-end and data set-up, and 20 ns for release. SPEED_GRADE 1 uses 70/70/35, 50/60/30 and 30 ns. At the default 4 ns clock and grade 0, a read lasts 14 cycles, a write 12 and the release wait 5.
- R3: A read keeps mem_cs_n and mem_oe_n at 0, mem_we_n at 1 and mem_dq_oe at 0 for exactly the read phase length. The strobes fall on the clock edge that accepts the request.
- R4: Read data is sampled from mem_dq_in on the edge that ends the read phase. rsp_rdata shows that byte, and rsp_valid is 1 for exactly the one cycle after that edge.
- R5: A write keeps mem_cs_n and mem_we_n at 0, mem_oe_n at 1, and mem_dq_oe at 1 with mem_dq_out equal to the accepted write data, for exactly the write phase length. All of them return to idle together.
- R6: mem_addr equals the accepted address and stays stable for the whole access. Changes on req_addr and req_wdata after acceptance have no effect.
- R7: After a read's strobes rise, req_ready stays 0 for the release-phase length. mem_dq_oe does not rise until at least that many cycles after mem_oe_n rose.
- R8: req_ready is 1 only in idle, with all three strobes at 1, and is 0 for the whole access. A request made while req_ready is 0 is ignored: it starts no access and writes nothing.
- R9: mem_oe_n and mem_we_n are never both 0. mem_dq_oe is 1 only while mem_we_n is 0. While mem_cs_n is 1 the other two strobes are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle; a request is taken on this cycle's edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle strobe marking rsp_rdata as new |
| rsp_rdata | output | 8 | Byte returned by the last read |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_addr | output | 15 | RAM address |
| mem_dq_out | output | 8 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enable for the data-bus drivers |
| mem_dq_in | input | 8 | Data seen on the RAM data bus |

## Verification
The assertions check the strobe rules on every cycle: no read and write overlap, drivers on only during write enable, and standby whenever chip select is high. They also check that the address stays still inside an access, that the valid strobe is single and follows a read, and that the drivers stay off through the release wait after output enable rises. The exact phase lengths for this clock and grade, the captured byte, and the write data placed in the RAM can only be shown by the bench. It does this with a memory model that returns garbage until the access time has passed. The bench also shows that requests made while busy are dropped.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_RD_WAIT  = 2'd1,
    ST_RD_TURN  = 2'd2,
    ST_WR_PULSE = 2'd3
  } seq_state_t;

  typedef enum logic [2:0] {
    TM_CYCLE,
    TM_ADDR_ACC,
    TM_OE_ACC,
    TM_WE_PULSE,
    TM_ADDR_END,
    TM_DATA_SET,
    TM_RELEASE
  } tm_item_t;

  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } mem_ctl_t;

  localparam mem_ctl_t CTL_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

  // Timing limit in ns for one item of one speed grade (0 = fast, else slow)
  function automatic int unsigned item_ns(int unsigned grade, tm_item_t item);
    int unsigned ns;
    case (item)
      TM_CYCLE:    ns = (grade == 0) ? 55 : 70;
      TM_ADDR_ACC: ns = (grade == 0) ? 55 : 70;
      TM_OE_ACC:   ns = (grade == 0) ? 25 : 35;
      TM_WE_PULSE: ns = (grade == 0) ? 40 : 50;
      TM_ADDR_END: ns = (grade == 0) ? 45 : 60;
      TM_DATA_SET: ns = (grade == 0) ? 25 : 30;
      TM_RELEASE:  ns = (grade == 0) ? 20 : 30;
      default:     ns = 1;
    endcase
    return ns;
  endfunction

  // Round a time up to whole clock cycles, never less than one
  function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned period);
    int unsigned c;
    if (period == 0) return 1;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned item_cycles(int unsigned grade, int unsigned period,
                                              tm_item_t item);
    return ns_to_cycles(item_ns(grade, item), period);
  endfunction

  function automatic int unsigned read_cycles(int unsigned grade, int unsigned period);
    return max2(max2(item_cycles(grade, period, TM_CYCLE),
                     item_cycles(grade, period, TM_ADDR_ACC)),
                item_cycles(grade, period, TM_OE_ACC));
  endfunction

  function automatic int unsigned write_cycles(int unsigned grade, int unsigned period);
    return max2(max2(item_cycles(grade, period, TM_WE_PULSE),
                     item_cycles(grade, period, TM_ADDR_END)),
                item_cycles(grade, period, TM_DATA_SET));
  endfunction

  function automatic int unsigned turn_cycles(int unsigned grade, int unsigned period);
    return item_cycles(grade, period, TM_RELEASE);
  endfunction

  // Bits needed to hold values 0..n
  function automatic int unsigned count_width(int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction

  // Strobe pattern for each sequencer state
  function automatic mem_ctl_t ctl_for(seq_state_t s);
    mem_ctl_t c;
    c = CTL_IDLE;
    case (s)
      ST_RD_WAIT: begin
        c.cs_n = 1'b0;
        c.oe_n = 1'b0;
      end
      ST_WR_PULSE: begin
        c.cs_n  = 1'b0;
        c.we_n  = 1'b0;
        c.dq_oe = 1'b1;
      end
      default: c = CTL_IDLE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int RD_CYC   = 14,
  parameter int WR_CYC   = 12,
  parameter int TURN_CYC = 5,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             phase_done,
  output seq_state_t       state_q,
  output seq_state_t       state_d,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             acc_start,
  output logic             rd_capture
);

  localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LOAD   = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_CYC - 1);

  always_comb begin
    state_d    = state_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    acc_start  = 1'b0;
    rd_capture = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          acc_start = 1'b1;
          tmr_load  = 1'b1;
          if (req_write) begin
            state_d = ST_WR_PULSE;
            tmr_val = WR_LOAD;
          end else begin
            state_d = ST_RD_WAIT;
            tmr_val = RD_LOAD;
          end
        end
      end
      ST_RD_WAIT: begin
        if (phase_done) begin
          rd_capture = 1'b1;
          state_d    = ST_RD_TURN;
          tmr_load   = 1'b1;
          tmr_val    = TURN_LOAD;
        end
      end
      ST_RD_TURN: begin
        if (phase_done) state_d = ST_IDLE;
      end
      ST_WR_PULSE: begin
        if (phase_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/asram_io.sv
module asram_io
  import asram_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_t        state_d,
  input  logic              acc_start,
  input  logic              rd_capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output mem_ctl_t          ctl_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  // Strobes are flops loaded from the next state, so they change on the
  // same edge as the sequencer and never glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_IDLE;
    else        ctl_q <= ctl_for(state_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (acc_start) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_capture;
      if (rd_capture) rsp_rdata <= mem_dq_in;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 4,
  parameter int SPEED_GRADE   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC   = int'(read_cycles(SPEED_GRADE, CLK_PERIOD_NS));
  localparam int WR_CYC   = int'(write_cycles(SPEED_GRADE, CLK_PERIOD_NS));
  localparam int TURN_CYC = int'(turn_cycles(SPEED_GRADE, CLK_PERIOD_NS));
  localparam int CYC_MAX  = int'(max2(max2(RD_CYC, WR_CYC), TURN_CYC));
  localparam int CNT_W    = int'(count_width(CYC_MAX));

  seq_state_t       state_q;
  seq_state_t       state_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             phase_done;
  logic             acc_start;
  logic             rd_capture;
  mem_ctl_t         ctl_q;

  asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (phase_done)
  );

  asram_seq #(
    .RD_CYC   (RD_CYC),
    .WR_CYC   (WR_CYC),
    .TURN_CYC (TURN_CYC),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .phase_done (phase_done),
    .state_q    (state_q),
    .state_d    (state_d),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .acc_start  (acc_start),
    .rd_capture (rd_capture)
  );

  asram_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_d    (state_d),
    .acc_start  (acc_start),
    .rd_capture (rd_capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .ctl_q      (ctl_q),
    .addr_q     (mem_addr),
    .wdata_q    (mem_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign mem_cs_n  = ctl_q.cs_n;
  assign mem_oe_n  = ctl_q.oe_n;
  assign mem_we_n  = ctl_q.we_n;
  assign mem_dq_oe = ctl_q.dq_oe;

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W   = 15,
  parameter int TURN_CYC = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              acc_start,
  input logic              rd_capture
);

  // Cycles since the RAM outputs were last enabled, saturating
  int unsigned since_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_oe <= TURN_CYC;
    else if (!mem_oe_n) since_oe <= 0;
    else if (since_oe < TURN_CYC) since_oe <= since_oe + 1;
  end

  assert_standby_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

  assert_no_rw_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  assert_drive_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n));

  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n));

  assert_start_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> !mem_cs_n);

  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

  assert_capture_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> rsp_valid);

  assert_single_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_valid_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !$past(mem_oe_n));

  assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (since_oe >= TURN_CYC));

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .TURN_CYC(TURN_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_cs_n   (mem_cs_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_dq_oe  (mem_dq_oe),
  .mem_addr   (mem_addr),
  .acc_start  (acc_start),
  .rd_capture (rd_capture)
);

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
module asram_ctrl_tb;

  // Expected phase lengths restated from R2 for a 4 ns clock, grade 0
  localparam int PER     = 4;
  localparam int RD_EXP  = (55 + PER - 1) / PER;   // 14
  localparam int WR_EXP  = (45 + PER - 1) / PER;   // 12
  localparam int HZ_EXP  = (20 + PER - 1) / PER;   // 5

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hEE;

  int checks = 0;
  int failures = 0;
  bit run_done = 0;

  always #2 clk = ~clk;

  asram_ctrl #(.CLK_PERIOD_NS(PER), .SPEED_GRADE(0)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // RAM model: stores while write strobes are low, returns 8'hEE until the
  // access time has passed since the outputs were enabled.
  logic [7:0] model_mem [int];
  int rd_age = 0;
  int oe_gap = 1000;
  bit seen_read = 0;

  always @(posedge clk) begin
    if (!mem_cs_n && !mem_we_n && mem_dq_oe) model_mem[int'(mem_addr)] = mem_dq_out;
  end

  always @(negedge clk) begin
    if (!mem_cs_n && !mem_oe_n) rd_age = rd_age + 1;
    else rd_age = 0;
    if (rd_age >= RD_EXP)
      mem_dq_in = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00;
    else
      mem_dq_in = 8'hEE;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R7 monitor: gap between output enable release and own drivers
  logic prev_dq_oe = 1'b0;
  always @(negedge clk) begin
    if (!mem_oe_n) begin
      oe_gap = 0;
      seen_read = 1;
    end else if (oe_gap < 1000) begin
      oe_gap = oe_gap + 1;
    end
    if (rst_n && mem_dq_oe && !prev_dq_oe && seen_read)
      check(oe_gap > HZ_EXP, "R7", "drivers on after release gap", oe_gap, HZ_EXP + 1);
    prev_dq_oe = mem_dq_oe;
  end

  task automatic do_op(input logic wr, input logic [14:0] a, input logic [7:0] d);
    int n;
    int m;
    bit bad_ctl;
    bit bad_addr;
    bit bad_busy;
    bit bad_pulse;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
    n = 0; bad_ctl = 0; bad_addr = 0; bad_busy = 0;
    while (mem_cs_n == 1'b0 && n < 1000) begin
      n++;
      if (mem_addr !== a) bad_addr = 1;
      if (req_ready) bad_busy = 1;
      if (wr) begin
        if (mem_we_n !== 1'b0 || mem_oe_n !== 1'b1 || mem_dq_oe !== 1'b1 || mem_dq_out !== d)
          bad_ctl = 1;
      end else begin
        if (mem_oe_n !== 1'b0 || mem_we_n !== 1'b1 || mem_dq_oe !== 1'b0 || rsp_valid)
          bad_ctl = 1;
      end
      @(negedge clk);
    end
    check(!bad_addr, "R6", "address held for access", bad_addr, 0);
    check(!bad_busy, "R8", "ready low during access", bad_busy, 0);
    if (wr) begin
      check(n == WR_EXP, "R2,R5", "write strobe cycles", n, WR_EXP);
      check(!bad_ctl, "R5", "write strobes and data", bad_ctl, 0);
      check(req_ready && mem_we_n && !mem_dq_oe, "R5", "idle after write", req_ready, 1);
    end else begin
      check(n == RD_EXP, "R2,R3", "read strobe cycles", n, RD_EXP);
      check(!bad_ctl, "R3", "read strobes", bad_ctl, 0);
      check(rsp_valid == 1'b1, "R4", "valid after read phase", rsp_valid, 1);
      check(rsp_rdata == d, "R4", "read data", rsp_rdata, d);
      m = 0; bad_pulse = 0;
      while (!req_ready && m < 1000) begin
        m++;
        if (m >= 2 && rsp_valid) bad_pulse = 1;
        if (mem_dq_oe || !mem_cs_n) bad_pulse = 1;
        @(negedge clk);
      end
      check(m == HZ_EXP, "R7", "release wait cycles", m, HZ_EXP);
      check(!bad_pulse && !rsp_valid, "R4", "single valid pulse", bad_pulse, 0);
    end
  endtask

  // Stimulus vectors: {write, address, data or expected read data}
  localparam int NVEC = 12;
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 15'h0000, 8'h3C},
    {1'b1, 15'h7FFF, 8'hC3},
    {1'b0, 15'h0000, 8'h3C},
    {1'b0, 15'h7FFF, 8'hC3},
    {1'b1, 15'h1234, 8'h5A},
    {1'b0, 15'h1234, 8'h5A},
    {1'b1, 15'h1234, 8'hA5},
    {1'b0, 15'h1234, 8'hA5},
    {1'b1, 15'h4000, 8'hFF},
    {1'b1, 15'h0001, 8'h00},
    {1'b0, 15'h0001, 8'h00},
    {1'b0, 15'h4000, 8'hFF}
  };

  task automatic finish_run();
    if (!run_done) begin
      run_done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R8 watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin : main
    int stray;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1", "strobes in reset",
          {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(req_ready && !rsp_valid, "R1", "ready and valid after reset",
          {req_ready, rsp_valid}, 2'b10);
    check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1,R9", "idle strobes",
          {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);

    for (int i = 0; i < NVEC; i++) begin
      do_op(VEC[i][23], VEC[i][22:8], VEC[i][7:0]);
    end

    // R8: request raised while busy with a read is ignored
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 15'h1234; req_wdata = 8'h00;
    @(negedge clk);
    stray = 0;
    req_write = 1'b1; req_addr = 15'h0100; req_wdata = 8'h77;
    for (int k = 0; k < 4; k++) begin
      if (mem_we_n !== 1'b1 || mem_cs_n !== 1'b0) stray++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (!req_ready) begin
      if (mem_we_n !== 1'b1) stray++;
      @(negedge clk);
    end
    check(rsp_rdata == 8'hA5, "R4", "read during busy-request test", rsp_rdata, 8'hA5);
    check(stray == 0, "R8", "no write strobe from ignored request", stray, 0);
    do_op(1'b0, 15'h0100, 8'h00);
    check(!model_mem.exists(32'h100), "R8", "ignored write left memory untouched",
          int'(model_mem.exists(32'h100)), 0);

    // R9: held idle with no request, strobes stay high
    repeat (3) @(negedge clk);
    check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready, "R9",
          "quiet idle", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);

    finish_run();
  end

endmodule